// File: doc/BRIEF.md
# Access-Class Endian Swap Path

This unit sits in the data path between a bus-master DMA engine and a 32-bit little-endian host bus. Each beat carries data, byte enables, an address and a tag that names the kind of access. When the big-endian mode bit is set, the unit reverses the byte lanes of the data, and mirrors the byte enables, for the two kinds of access that hold structured dword entries: descriptor-table entries and fragment-list entries.

Packet payload, configuration-space traffic and control-register traffic always pass through untouched, whatever the mode. With the mode bit clear, every beat passes through unchanged. Addresses are never altered.

The unit holds one register stage with a valid/ready handshake. The swap decision is made when a beat is accepted, so a change of mode applies from the next accepted beat onward.

Top module: `endsw_path`

## Requirements
- R1: With `big_endian`=1, a beat of class 0 (descriptor entry) leaves with data lanes reversed: byte lane k (bits 8k+7..8k) of the output holds input byte lane 3-k.
- R2: With `big_endian`=1, a beat of class 1 (fragment-list entry) leaves with its data lanes reversed in the same way as R1.
- R3: Beats of class 3 (configuration space) and class 4 (control register) leave with data and byte enables unchanged, whatever `big_endian` is.
- R4: Beats of class 2 (packet payload) leave with data and byte enables unchanged, whatever `big_endian` is.
- R5: With `big_endian`=0, every class passes through unchanged. Class codes 5 to 7 pass through unchanged in either mode.
- R6: `out_addr` always equals the `in_addr` of the same beat.
- R7: When a beat's data is reversed, its byte enables are mirrored too: output bit k equals input bit 3-k.
- R8: A beat accepted on a clock edge (`in_valid`=1 and `in_ready`=1) appears on the outputs with `out_valid`=1 after that edge. `in_ready` equals (!`out_valid` || `out_ready`). While `out_valid`=1 and `out_ready`=0, the outputs hold steady.
- R9: `big_endian` is sampled when a beat is accepted. A change while a beat is held does not alter that beat.
- R10: While reset is asserted, and after it is released, `out_valid` is 0 until a beat is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| big_endian | input | 1 | Big-endian mode enable |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Unit can accept a beat |
| in_class | input | 3 | Access class code (0 desc, 1 frag, 2 packet, 3 config, 4 control) |
| in_addr | input | 32 | Beat address |
| in_data | input | 32 | Beat data |
| in_be | input | 4 | Beat byte enables |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Consumer accepts output beat |
| out_addr | output | 32 | Address, unchanged |
| out_data | output | 32 | Data, reversed or not |
| out_be | output | 4 | Byte enables, mirrored or not |

## Verification
The bench interleaves all eight class codes with both mode values, so a decoder that also swapped packet or register traffic, or swapped with the mode clear, shows up as reordered bytes on those classes. Random back-pressure holds beats for several cycles while the mode toggles. A design that read the mode live instead of latching it at acceptance would change a held beat, and one that lost the hold would drop or repeat beats. Asymmetric byte-enable patterns catch enables that are left unmirrored, or mirrored in the wrong order, while the data is correct.

// File: rtl/endsw_pkg.sv
package endsw_pkg;

  localparam int CLASS_W = 3;

  localparam logic [CLASS_W-1:0] ACC_DESC = 3'd0;
  localparam logic [CLASS_W-1:0] ACC_FRAG = 3'd1;
  localparam logic [CLASS_W-1:0] ACC_PKT  = 3'd2;
  localparam logic [CLASS_W-1:0] ACC_CFG  = 3'd3;
  localparam logic [CLASS_W-1:0] ACC_CTRL = 3'd4;

endpackage

// File: rtl/endsw_rst_sync.sv
module endsw_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/endsw_policy.sv
module endsw_policy
  import endsw_pkg::*;
(
  input  logic               big_endian,
  input  logic [CLASS_W-1:0] acc_class,
  output logic               do_swap
);

  logic class_struct;

  always_comb begin
    case (acc_class)
      ACC_DESC, ACC_FRAG: class_struct = 1'b1;
      ACC_PKT, ACC_CFG, ACC_CTRL: class_struct = 1'b0;
      default: class_struct = 1'b0;
    endcase
  end

  assign do_swap = big_endian & class_struct;

endmodule

// File: rtl/endsw_lane_rev.sv
module endsw_lane_rev #(
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    en,
  input  logic [LANES*LANE_W-1:0] din,
  input  logic [LANES-1:0]        be_in,
  output logic [LANES*LANE_W-1:0] dout,
  output logic [LANES-1:0]        be_out
);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam int MIR = LANES - 1 - i;
    assign dout[i*LANE_W +: LANE_W] = en ? din[MIR*LANE_W +: LANE_W]
                                         : din[i*LANE_W +: LANE_W];
    assign be_out[i] = en ? be_in[MIR] : be_in[i];
  end

endmodule

// File: rtl/endsw_stage.sv
module endsw_stage #(
  parameter int W = 68
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_payload,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_payload
);

  logic         valid_q, valid_d;
  logic [W-1:0] pay_q;
  logic         load_en;

  always_comb begin
    in_ready = !valid_q || out_ready;
    load_en  = in_valid && in_ready;
    valid_d  = valid_q;
    if (load_en)        valid_d = 1'b1;
    else if (out_ready) valid_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (load_en) pay_q <= in_payload;
  end

  assign out_valid   = valid_q;
  assign out_payload = pay_q;

  // R8: a stalled beat stays put
  a_r8_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_payload)));

  // R8: an accepted beat is presented on the next cycle
  a_r8_accept_shows: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_valid && out_payload == $past(in_payload)));

endmodule

// File: rtl/endsw_path.sv
module endsw_path
  import endsw_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int LANE_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   big_endian,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [CLASS_W-1:0]     in_class,
  input  logic [ADDR_W-1:0]      in_addr,
  input  logic [DATA_W-1:0]      in_data,
  input  logic [DATA_W/LANE_W-1:0] in_be,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [ADDR_W-1:0]      out_addr,
  output logic [DATA_W-1:0]      out_data,
  output logic [DATA_W/LANE_W-1:0] out_be
);

  localparam int LANES = DATA_W / LANE_W;
  localparam int PAY_W = ADDR_W + LANES + DATA_W;

  logic              rst_sync_n;
  logic              do_swap;
  logic [DATA_W-1:0] sw_data;
  logic [LANES-1:0]  sw_be;
  logic [PAY_W-1:0]  pay_in, pay_out;

  endsw_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  endsw_policy u_policy (
    .big_endian (big_endian),
    .acc_class  (in_class),
    .do_swap    (do_swap)
  );

  endsw_lane_rev #(.LANES(LANES), .LANE_W(LANE_W)) u_rev (
    .en     (do_swap),
    .din    (in_data),
    .be_in  (in_be),
    .dout   (sw_data),
    .be_out (sw_be)
  );

  assign pay_in = {in_addr, sw_be, sw_data};

  endsw_stage #(.W(PAY_W)) u_stage (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .in_payload  (pay_in),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_payload (pay_out)
  );

  assign out_addr = pay_out[PAY_W-1 -: ADDR_W];
  assign out_be   = pay_out[DATA_W +: LANES];
  assign out_data = pay_out[DATA_W-1:0];

  // Checking helpers: behavioural lane reversal
  function automatic logic [DATA_W-1:0] rev_bytes(input logic [DATA_W-1:0] d);
    logic [DATA_W-1:0] r;
    for (int k = 0; k < LANES; k++) r[k*LANE_W +: LANE_W] = d[(LANES-1-k)*LANE_W +: LANE_W];
    return r;
  endfunction

  function automatic logic [LANES-1:0] rev_be(input logic [LANES-1:0] b);
    logic [LANES-1:0] r;
    for (int k = 0; k < LANES; k++) r[k] = b[LANES-1-k];
    return r;
  endfunction

  logic acc_fire;
  assign acc_fire = in_valid && in_ready;

  // R1: descriptor beats reversed in big-endian mode
  a_r1_desc_swap: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (acc_fire && big_endian && in_class == ACC_DESC) |=> (out_data == rev_bytes($past(in_data))));

  // R2: fragment-list beats reversed in big-endian mode
  a_r2_frag_swap: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (acc_fire && big_endian && in_class == ACC_FRAG) |=> (out_data == rev_bytes($past(in_data))));

  // R3: register space never reversed
  a_r3_reg_pass: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (acc_fire && (in_class == ACC_CFG || in_class == ACC_CTRL))
      |=> (out_data == $past(in_data) && out_be == $past(in_be)));

  // R4: packet payload never reversed
  a_r4_pkt_pass: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (acc_fire && in_class == ACC_PKT) |=> (out_data == $past(in_data) && out_be == $past(in_be)));

  // R5: little-endian mode passes everything
  a_r5_le_pass: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (acc_fire && !big_endian) |=> (out_data == $past(in_data) && out_be == $past(in_be)));

  // R6: address untouched
  a_r6_addr_kept: assert property (@(posedge clk) disable iff (!rst_sync_n)
    acc_fire |=> (out_addr == $past(in_addr)));

  // R7: enables mirrored together with reversed data
  a_r7_be_mirror: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (acc_fire && big_endian && (in_class == ACC_DESC || in_class == ACC_FRAG))
      |=> (out_be == rev_be($past(in_be))));

  // R10: no output beat straight out of reset
  a_r10_reset_idle: assert property (@(posedge clk)
    (!rst_sync_n) |=> !out_valid || $past(acc_fire));

endmodule

// File: tb/endsw_path_tb.sv
module endsw_path_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        big_endian, in_valid, in_ready, out_valid, out_ready;
  logic [2:0]  in_class;
  logic [31:0] in_addr, in_data, out_addr, out_data;
  logic [3:0]  in_be, out_be;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  endsw_path u_dut (
    .clk(clk), .rst_n(rst_n), .big_endian(big_endian),
    .in_valid(in_valid), .in_ready(in_ready), .in_class(in_class),
    .in_addr(in_addr), .in_data(in_data), .in_be(in_be),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_addr(out_addr), .out_data(out_data), .out_be(out_be)
  );

  // reference model state
  bit          m_valid;
  logic [31:0] m_data, m_addr;
  logic [3:0]  m_be;
  string       m_tag;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] ref_rev(input logic [31:0] d);
    logic [31:0] r;
    for (int k = 0; k < 4; k++) r[8*k +: 8] = d[8*(3-k) +: 8];
    return r;
  endfunction

  function automatic logic [3:0] ref_mirror(input logic [3:0] b);
    return {b[0], b[1], b[2], b[3]};
  endfunction

  function automatic string tag_for(input logic [2:0] c, input bit m);
    if (c > 3'd4 || !m) return "R5";
    case (c)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R4";
      default: return "R3";
    endcase
  endfunction

  task automatic step(input bit v, input logic [2:0] c, input bit m, input logic [31:0] d,
                      input logic [3:0] b, input logic [31:0] a, input bit ordy);
    bit rdy, sw;
    @(negedge clk);
    in_valid = v; in_class = c; big_endian = m; in_data = d;
    in_be = b; in_addr = a; out_ready = ordy;
    #1;
    rdy = !m_valid || ordy;
    chk(in_ready == rdy, "R8", {31'd0, in_ready}, {31'd0, rdy});
    chk(out_valid == m_valid, "R8", {31'd0, out_valid}, {31'd0, m_valid});
    if (m_valid) begin
      chk(out_data == m_data, m_tag, out_data, m_data);
      chk(out_be == m_be, "R7", {28'd0, out_be}, {28'd0, m_be});
      chk(out_addr == m_addr, "R6", out_addr, m_addr);
    end
    if (v && rdy) begin
      sw = m && (c == 3'd0 || c == 3'd1);
      m_valid = 1'b1;
      m_data  = sw ? ref_rev(d) : d;
      m_be    = sw ? ref_mirror(b) : b;
      m_addr  = a;
      m_tag   = tag_for(c, m);
    end else if (ordy) begin
      m_valid = 1'b0;
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_class = 3'd0; big_endian = 1'b0;
    in_data = '0; in_be = '0; in_addr = '0; out_ready = 1'b0;
    m_valid = 1'b0; m_tag = "R5";
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R10", {31'd0, out_valid}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(out_valid == 1'b0, "R10", {31'd0, out_valid}, 32'd0);

    // R1 / R7 directed: descriptor in big-endian mode
    step(1, 3'd0, 1, 32'h11223344, 4'b0011, 32'hA000_0010, 1);
    // R2: fragment list
    step(1, 3'd1, 1, 32'hA1B2C3D4, 4'b0001, 32'hA000_0020, 1);
    // R4: packet untouched in big-endian mode
    step(1, 3'd2, 1, 32'hDEADBEEF, 4'b0111, 32'hA000_0030, 1);
    // R3: config and control untouched
    step(1, 3'd3, 1, 32'h01020304, 4'b1000, 32'hA000_0040, 1);
    step(1, 3'd4, 1, 32'h05060708, 4'b0110, 32'hA000_0050, 1);
    // R5: undefined code and little-endian descriptor
    step(1, 3'd6, 1, 32'h0A0B0C0D, 4'b0010, 32'hA000_0060, 1);
    step(1, 3'd0, 0, 32'h11223344, 4'b0011, 32'hA000_0070, 1);
    step(0, 3'd0, 0, 32'h0, 4'b0, 32'h0, 1);

    // R9: descriptor latched in big-endian mode, mode drops while held
    step(1, 3'd0, 1, 32'h55667788, 4'b0001, 32'hB000_0000, 0);
    step(0, 3'd0, 0, 32'h0, 4'b0, 32'h0, 0);
    step(0, 3'd0, 0, 32'h0, 4'b0, 32'h0, 0);
    chk(out_data == 32'h88776655, "R9", out_data, 32'h88776655);
    chk(out_be == 4'b1000, "R9", {28'd0, out_be}, 32'h8);
    step(0, 3'd0, 0, 32'h0, 4'b0, 32'h0, 1);
    step(0, 3'd0, 0, 32'h0, 4'b0, 32'h0, 1);

    // random mix with back-pressure and mode toggling
    for (int i = 0; i < 4000; i++) begin
      step($urandom_range(0, 3) != 0, 3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)),
           $urandom, 4'($urandom), $urandom, $urandom_range(0, 2) != 0);
    end
    for (int i = 0; i < 4; i++) step(0, 3'd0, 0, 32'h0, 4'b0, 32'h0, 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule